// File: doc/BRIEF.md
# Symbolic and Arithmetic Instruction Predication Gate

This block decides, for every instruction reaching the execute stage, whether that instruction is allowed to take effect. Each instruction carries a 4-bit condition selector. The gate tests that selector against two groups of inputs. The first group holds seven symbolic flags from the tag, bounds and trail logic of a logic-programming datapath. The second group holds the four arithmetic condition codes. When the selected condition is false, the instruction turns into a nop. Its register write, memory write, branch and condition-code update strobes are all forced low.

The flags are sampled in the same cycle as the instruction's execute stage, so they carry the values left by the preceding instruction. The result is registered. The enable and the gated strobes appear on the outputs one clock after the instruction is presented. Instruction decode and the flag producers sit outside the block.

Selector encoding:

| Selector | Condition |
|---|---|
| 0 | always |
| 1 | first operand bound, `sym_flags[0]` |
| 2 | second operand bound, `sym_flags[1]` |
| 3 | first operand needs trailing, `sym_flags[2]` |
| 4 | second operand needs trailing, `sym_flags[3]` |
| 5 | first environment check, `sym_flags[4]` |
| 6 | second environment check, `sym_flags[5]` |
| 7 | sticky stack-collision overflow, `sym_flags[6]` |
| 8 | equal (Z) |
| 9 | not equal (!Z) |
| 10 | signed less than (N xor V) |
| 11 | signed greater or equal (not (N xor V)) |
| 12 | carry set (C) |
| 13 | overflow set (V) |
| 14, 15 | never |

Top module: `pred_gate`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, all outputs are 0.
- R2: Selector 0 always executes: a valid instruction with selector 0 gives `insn_en` = 1 one clock later, whatever the flags are.
- R3: Selectors 1 to 7 execute exactly when `sym_flags[selector-1]` is 1. The bit order is bound first, bound second, trail first, trail second, environment first, environment second, sticky overflow.
- R4: Selector 8 executes when `cc_z` is 1, and selector 9 executes when `cc_z` is 0.
- R5: Selector 10 executes when `cc_n` xor `cc_v` is 1, and selector 11 executes when it is 0.
- R6: Selector 12 executes when `cc_c` is 1, and selector 13 executes when `cc_v` is 1.
- R7: Selectors 14 and 15 never execute, whatever the flags are.
- R8: When `insn_en` is 0, `reg_we`, `mem_we`, `branch_take` and `cc_we` are all 0. A suppressed instruction therefore updates neither the condition codes nor any register or memory, and it does not branch.
- R9: When `insn_en` is 1, each gated strobe equals the matching request strobe of that instruction.
- R10: When `issue_valid` is 0, `insn_en` and all strobes are 0 one clock later, whatever the selector and flags are.
- R11: The outputs change only at a clock edge. They reflect the inputs present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is in the execute stage |
| cond_sel | input | 4 | Condition selector of the instruction |
| req_reg_we | input | 1 | Decoded register-write request |
| req_mem_we | input | 1 | Decoded memory-write request |
| req_branch | input | 1 | Decoded branch request |
| req_cc_we | input | 1 | Decoded condition-code update request |
| sym_flags | input | 7 | Symbolic flags, bit order as in R3 |
| cc_z | input | 1 | Zero condition code |
| cc_n | input | 1 | Negative condition code |
| cc_c | input | 1 | Carry condition code |
| cc_v | input | 1 | Overflow condition code |
| insn_en | output | 1 | Registered: the instruction takes effect |
| reg_we | output | 1 | Gated register write |
| mem_we | output | 1 | Gated memory write |
| branch_take | output | 1 | Gated branch strobe |
| cc_we | output | 1 | Gated condition-code update |

## Verification
The symbolic selectors are tried with walking-one and walking-zero flag vectors. This shows that each selector reads its own bit and no neighbour. The arithmetic selectors are swept across all sixteen Z/N/C/V combinations, which separates LT from GE and carry from overflow, and catches a swapped polarity. The reserved selectors are driven with every flag set, and the always selector with every flag clear. Distinct request-strobe patterns show that each gated strobe follows its own request, and that a suppressed or invalid instruction clears all four strobes, including the condition-code update.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int COND_W   = 4;
  localparam int SYM_N    = 7;
  localparam int NSTB     = 4;
  localparam int SYM_BASE = 1;
  localparam int ARITH_BASE = SYM_BASE + SYM_N;

  // strobe vector bit positions
  localparam int STB_REG = 0;
  localparam int STB_MEM = 1;
  localparam int STB_BR  = 2;
  localparam int STB_CC  = 3;

  typedef enum logic [COND_W-1:0] {
    SEL_ALWAYS = COND_W'(0),
    SEL_EQ     = COND_W'(ARITH_BASE + 0),
    SEL_NE     = COND_W'(ARITH_BASE + 1),
    SEL_LT     = COND_W'(ARITH_BASE + 2),
    SEL_GE     = COND_W'(ARITH_BASE + 3),
    SEL_CS     = COND_W'(ARITH_BASE + 4),
    SEL_VS     = COND_W'(ARITH_BASE + 5)
  } sel_e;
endpackage

// File: rtl/cond_select.sv
module cond_select
  import pred_pkg::*;
#(
  parameter int CW   = COND_W,
  parameter int NSYM = SYM_N
) (
  input  logic [CW-1:0]   sel,
  input  logic [NSYM-1:0] sym,
  input  logic            z,
  input  logic            n,
  input  logic            c,
  input  logic            v,
  output logic            hit
);
  logic [NSYM-1:0] sym_pick;
  logic            sym_hit;
  logic            arith_hit;

  for (genvar i = 0; i < NSYM; i++) begin : g_sym
    assign sym_pick[i] = (sel == CW'(SYM_BASE + i));
  end

  assign sym_hit = |(sym_pick & sym);

  always_comb begin
    case (sel)
      SEL_EQ:  arith_hit = z;
      SEL_NE:  arith_hit = ~z;
      SEL_LT:  arith_hit = n ^ v;
      SEL_GE:  arith_hit = ~(n ^ v);
      SEL_CS:  arith_hit = c;
      SEL_VS:  arith_hit = v;
      default: arith_hit = 1'b0;
    endcase
  end

  assign hit = (sel == SEL_ALWAYS) | sym_hit | arith_hit;

  // R3
  always_comb begin
    if (sel != SEL_ALWAYS && sel < CW'(ARITH_BASE)) begin
      sym_onehot_chk: assert ($onehot(sym_pick));
    end
  end

  // R7
  always_comb begin
    if (sel > CW'(ARITH_BASE + 5)) begin
      reserved_never_chk: assert (!sym_hit && !arith_hit);
    end
  end
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         hit,
  input  logic [N-1:0] req,
  output logic         en_q,
  output logic [N-1:0] stb_q
);
  logic en_d;
  assign en_d = valid & hit;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_d;
  end

  for (genvar k = 0; k < N; k++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) stb_q[k] <= 1'b0;
      else     stb_q[k] <= en_d & req[k];
    end
  end

  // R8
  suppress_all_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (stb_q == '0));
endmodule

// File: rtl/pred_gate.sv
module pred_gate
  import pred_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [COND_W-1:0] cond_sel,
  input  logic              req_reg_we,
  input  logic              req_mem_we,
  input  logic              req_branch,
  input  logic              req_cc_we,
  input  logic [SYM_N-1:0]  sym_flags,
  input  logic              cc_z,
  input  logic              cc_n,
  input  logic              cc_c,
  input  logic              cc_v,
  output logic              insn_en,
  output logic              reg_we,
  output logic              mem_we,
  output logic              branch_take,
  output logic              cc_we
);
  logic            cond_hit;
  logic [NSTB-1:0] req_vec;
  logic [NSTB-1:0] stb_vec;

  assign req_vec[STB_REG] = req_reg_we;
  assign req_vec[STB_MEM] = req_mem_we;
  assign req_vec[STB_BR]  = req_branch;
  assign req_vec[STB_CC]  = req_cc_we;

  cond_select #(.CW(COND_W), .NSYM(SYM_N)) i_sel (
    .sel (cond_sel),
    .sym (sym_flags),
    .z   (cc_z),
    .n   (cc_n),
    .c   (cc_c),
    .v   (cc_v),
    .hit (cond_hit)
  );

  strobe_gate #(.N(NSTB)) i_gate (
    .clk   (clk),
    .rst   (rst),
    .valid (issue_valid),
    .hit   (cond_hit),
    .req   (req_vec),
    .en_q  (insn_en),
    .stb_q (stb_vec)
  );

  assign reg_we      = stb_vec[STB_REG];
  assign mem_we      = stb_vec[STB_MEM];
  assign branch_take = stb_vec[STB_BR];
  assign cc_we       = stb_vec[STB_CC];

  // R2
  always_exec_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_valid) && $past(cond_sel) == SEL_ALWAYS) |-> insn_en);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(issue_valid)) |-> (!insn_en && !reg_we && !mem_we && !branch_take && !cc_we));

  // R9
  pass_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && insn_en) |-> (reg_we == $past(req_reg_we) && mem_we == $past(req_mem_we)
                                  && branch_take == $past(req_branch) && cc_we == $past(req_cc_we)));

  // R7
  reserved_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_sel) > COND_W'(ARITH_BASE + 5)) |-> !insn_en);
endmodule

// File: tb/test_pred_gate.sv
module test_pred_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [3:0] cond_sel = '0;
  logic       req_reg_we = 1'b0, req_mem_we = 1'b0, req_branch = 1'b0, req_cc_we = 1'b0;
  logic [6:0] sym_flags = '0;
  logic       cc_z = 1'b0, cc_n = 1'b0, cc_c = 1'b0, cc_v = 1'b0;
  logic       insn_en, reg_we, mem_we, branch_take, cc_we;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pred_gate i_pred_gate (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .cond_sel(cond_sel),
    .req_reg_we(req_reg_we), .req_mem_we(req_mem_we), .req_branch(req_branch),
    .req_cc_we(req_cc_we), .sym_flags(sym_flags),
    .cc_z(cc_z), .cc_n(cc_n), .cc_c(cc_c), .cc_v(cc_v),
    .insn_en(insn_en), .reg_we(reg_we), .mem_we(mem_we),
    .branch_take(branch_take), .cc_we(cc_we)
  );

  function automatic logic model_cond(input logic [3:0] s, input logic [6:0] f,
                                      input logic z, input logic n, input logic c, input logic v);
    if (s == 4'd0) return 1'b1;
    if (s <= 4'd7) return f[s - 4'd1];
    case (s)
      4'd8:  return z;
      4'd9:  return !z;
      4'd10: return n != v;
      4'd11: return n == v;
      4'd12: return c;
      4'd13: return v;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {en,reg,mem,br,cc} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {insn_en, reg_we, mem_we, branch_take, cc_we};
  endfunction

  // present one instruction at negedge, sample at the following negedge
  task automatic issue(input string req, input logic vld, input logic [3:0] s, input logic [3:0] rq,
                       input logic [6:0] f, input logic [3:0] zncv);
    logic e;
    issue_valid = vld; cond_sel = s;
    {req_reg_we, req_mem_we, req_branch, req_cc_we} = rq;
    sym_flags = f;
    {cc_z, cc_n, cc_c, cc_v} = zncv;
    e = vld & model_cond(s, f, zncv[3], zncv[2], zncv[1], zncv[0]);
    @(posedge clk);
    @(negedge clk);
    check(req, outs(), {e, e ? rq : 4'b0000});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    issue_valid = 1'b1; cond_sel = 4'd0;
    {req_reg_we, req_mem_we, req_branch, req_cc_we} = 4'b1111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", outs(), 5'b0);
    rst = 1'b0;
    issue_valid = 1'b0;
  endtask

  task automatic t_always();
    issue("R2", 1'b1, 4'd0, 4'b1111, 7'h00, 4'b0000);
    issue("R2", 1'b1, 4'd0, 4'b1010, 7'h7f, 4'b1111);
  endtask

  task automatic t_symbolic();
    for (int i = 0; i < 7; i++) begin
      issue("R3", 1'b1, 4'(i + 1), 4'b1001, 7'(1 << i), 4'b0000);
      issue("R3", 1'b1, 4'(i + 1), 4'b1001, ~7'(1 << i), 4'b1111);
      // neighbour bit set only: must not execute
      issue("R3", 1'b1, 4'(i + 1), 4'b0110, 7'(1 << ((i + 1) % 7)), 4'b0000);
    end
  endtask

  task automatic t_arith();
    for (int f = 0; f < 16; f++) begin
      issue("R4", 1'b1, 4'd8,  4'b0101, 7'h00, 4'(f));
      issue("R4", 1'b1, 4'd9,  4'b0101, 7'h00, 4'(f));
      issue("R5", 1'b1, 4'd10, 4'b0011, 7'h00, 4'(f));
      issue("R5", 1'b1, 4'd11, 4'b0011, 7'h00, 4'(f));
      issue("R6", 1'b1, 4'd12, 4'b1100, 7'h00, 4'(f));
      issue("R6", 1'b1, 4'd13, 4'b1100, 7'h00, 4'(f));
    end
  endtask

  task automatic t_reserved();
    issue("R7", 1'b1, 4'd14, 4'b1111, 7'h7f, 4'b1111);
    issue("R7", 1'b1, 4'd15, 4'b1111, 7'h7f, 4'b1111);
    issue("R7", 1'b1, 4'd15, 4'b1111, 7'h00, 4'b0000);
  endtask

  task automatic t_suppress();
    // false condition with every request set: all strobes incl. cc update low
    issue("R8", 1'b1, 4'd8, 4'b1111, 7'h7f, 4'b0111);
    issue("R8", 1'b1, 4'd1, 4'b0001, 7'h7e, 4'b1111);
    // true condition, distinct request patterns pass through
    for (int p = 0; p < 16; p++) issue("R9", 1'b1, 4'd12, 4'(p), 7'h00, 4'b0010);
  endtask

  task automatic t_invalid();
    issue("R10", 1'b0, 4'd0, 4'b1111, 7'h7f, 4'b1111);
    issue("R10", 1'b0, 4'd7, 4'b1111, 7'h7f, 4'b1111);
  endtask

  task automatic t_latency();
    issue("R11", 1'b1, 4'd0, 4'b1111, 7'h00, 4'b0000);
    issue_valid = 1'b0; cond_sel = 4'd15;
    #2;
    check("R11", outs(), 5'b11111);
    @(posedge clk);
    @(negedge clk);
    check("R11", outs(), 5'b00000);
  endtask

  initial begin
    t_reset();
    t_always();
    t_symbolic();
    t_arith();
    t_reserved();
    t_suppress();
    t_invalid();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule